// File: doc/BRIEF.md
# Variable-Page-Size Fully-Associative TLB

A translation buffer whose entries are searched all at once. Each entry maps one page of 8 KB, 64 KB, 512 KB or 4 MB. The page size is chosen per entry by a 2-bit size code. An entry carries a 13-bit context tag, a global flag and the attributes privileged, write-ok, no-fault-only and side-effect. A lookup presents the virtual page number, the access kind, the privilege of the requester and the context inputs. One cycle later the block returns a 41-bit physical address, the granted read/write permission and an exception class.

A write port loads one entry by index, and software chooses the victim. A successful lookup marks the entry as used. Any lookup that misses or faults loads a tag register with the virtual page and the context that was in effect, so that a refill handler can pick them up.

Top module: `vps_tlb`

## Requirements
- R1: An entry of size code s (0..3) covers 8192<<(3*s) bytes. It matches when it is valid and every virtual address bit at or above 13+3*s equals the entry's tag.
- R2: A match also needs the entry's global flag or equal 13-bit contexts. Loads and stores use sec_ctx when lk_sec=1 and prim_ctx otherwise. Fetches use prim_ctx when lk_trap=0 and context 0 when lk_trap=1.
- R3: On a hit, rsp_pa is the entry's physical page bits above the page offset joined with the virtual address bits inside the page. The result is 41 bits wide, with bits 12:0 zero.
- R4: An access fault (rsp_exc=3) is raised by any of three conditions, and rsp_ft holds one bit per condition: bit2 for a user access to a privileged entry, bit1 for a no-fault load (kind 3) to a side-effect entry, and bit0 for a load or store (kind 0/1) to a no-fault-only entry. Several bits may be set together. A fetch (kind 2) checks only privilege.
- R5: A store (kind 1) that raises no access fault, made to an entry without write-ok, gives a protection exception (rsp_exc=2) with rsp_ft=0.
- R6: A hit with no fault gives rsp_exc=0 and rsp_rd=1, with rsp_wr equal to the entry's write-ok flag. Any exception forces rsp_rd and rsp_wr to 0.
- R7: rsp_was_used shows the hitting entry's used bit before the lookup. A successful lookup sets that bit, a faulting lookup leaves it alone, and a write to the entry clears it. A write on the same edge wins.
- R8: A lookup that matches no entry gives rsp_exc=1, rsp_hit=0 and rsp_pa=0.
- R9: Every lookup that ends with rsp_exc other than 0 loads tag_access with {virtual address bits 63:13, selected context}. A successful lookup leaves tag_access unchanged.
- R10: When several entries match, the one with the lowest index supplies every result.
- R11: Results appear on the first clock edge after lk_valid, with rsp_valid high for exactly that cycle. After reset all entries are invalid and rsp_valid and tag_access are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | log2(ENTRIES) | Entry index to load |
| wr_valid | input | 1 | Valid flag of the loaded entry |
| wr_vpn | input | VA_W-13 | Virtual page tag (address bits 63:13) |
| wr_ctx | input | CTX_W | Context tag |
| wr_ppn | input | PA_W-13 | Physical page bits 40:13 |
| wr_size | input | 2 | Page size code: 0 8 KB, 1 64 KB, 2 512 KB, 3 4 MB |
| wr_global | input | 1 | Ignore the context on match |
| wr_priv | input | 1 | Privileged-only page |
| wr_wok | input | 1 | Write permitted |
| wr_nfo | input | 1 | No-fault-only page |
| wr_se | input | 1 | Page has side effects |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VA_W-13 | Virtual address bits 63:13 |
| lk_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 no-fault load |
| lk_user | input | 1 | Requester is unprivileged |
| lk_sec | input | 1 | Data access uses the secondary context |
| lk_trap | input | 1 | Trap level is nonzero |
| prim_ctx | input | CTX_W | Primary context |
| sec_ctx | input | CTX_W | Secondary context |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_pa | output | PA_W | Physical address |
| rsp_exc | output | 2 | 0 none, 1 miss, 2 protection, 3 access fault |
| rsp_ft | output | 3 | Access fault causes {priv, side-effect, no-fault-only} |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_was_used | output | 1 | Used bit of the hitting entry before this lookup |
| tag_access | output | VA_W-13+CTX_W | Virtual page and context of the last miss or fault |

## Verification
The case hardest to reach from the ports is several attribute checks failing on one entry together, or a protection check hidden behind an access fault. An input sweep rewrites a single live entry with every combination of the five attribute flags. It then issues each access kind from both privilege levels, so that every ordering between access fault and protection is seen. Entries of all four sizes are probed at their first and last bytes and one byte past each end. The physical base is given deliberately stray low bits, which must not show through.

// File: rtl/vps_tlb.sv
module vps_tlb #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PG_LSB = 13,
  localparam int VT_W   = VA_W - PG_LSB,
  localparam int PP_W   = PA_W - PG_LSB,
  localparam int TA_W   = VT_W + CTX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VT_W-1:0]  wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PP_W-1:0]  wr_ppn,
  input  logic [1:0]       wr_size,
  input  logic             wr_global,
  input  logic             wr_priv,
  input  logic             wr_wok,
  input  logic             wr_nfo,
  input  logic             wr_se,
  input  logic             lk_valid,
  input  logic [VT_W-1:0]  lk_vpn,
  input  logic [1:0]       lk_kind,
  input  logic             lk_user,
  input  logic             lk_sec,
  input  logic             lk_trap,
  input  logic [CTX_W-1:0] prim_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_exc,
  output logic [2:0]       rsp_ft,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_was_used,
  output logic [TA_W-1:0]  tag_access
);

  logic [VT_W-1:0]    e_vpn  [ENTRIES];
  logic [CTX_W-1:0]   e_ctx  [ENTRIES];
  logic [PP_W-1:0]    e_ppn  [ENTRIES];
  logic [1:0]         e_size [ENTRIES];
  logic [ENTRIES-1:0] e_v, e_g, e_p, e_w, e_nfo, e_se, e_used;

  logic [CTX_W-1:0]   ctx;
  logic [ENTRIES-1:0] match;
  logic               hit;
  logic [IDX_W-1:0]   sel;
  logic [PP_W-1:0]    pmask, ppn;
  logic [2:0]         ft;
  logic               is_st, is_if, is_nf, afault, prot, ok;
  logic [1:0]         exc;

  assign is_st = lk_kind == 2'd1;
  assign is_if = lk_kind == 2'd2;
  assign is_nf = lk_kind == 2'd3;

  assign ctx = is_if ? (lk_trap ? '0 : prim_ctx) : (lk_sec ? sec_ctx : prim_ctx);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VT_W-1:0] vmask;
    assign vmask    = {VT_W{1'b1}} << (3 * e_size[g]);
    assign match[g] = e_v[g] && (((e_vpn[g] ^ lk_vpn) & vmask) == '0)
                      && (e_g[g] || e_ctx[g] == ctx);
  end

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign pmask = {PP_W{1'b1}} << (3 * e_size[sel]);
  assign ppn   = (e_ppn[sel] & pmask) | (lk_vpn[PP_W-1:0] & ~pmask);

  assign ft = hit ? {e_p[sel] & lk_user,
                     is_nf & e_se[sel],
                     ~is_if & ~is_nf & e_nfo[sel]} : 3'b000;
  assign afault = |ft;
  assign prot   = hit & ~afault & is_st & ~e_w[sel];
  assign ok     = hit & ~afault & ~prot;
  assign exc    = !hit ? 2'd1 : afault ? 2'd3 : prot ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_idx]  <= wr_vpn;
      e_ctx[wr_idx]  <= wr_ctx;
      e_ppn[wr_idx]  <= wr_ppn;
      e_size[wr_idx] <= wr_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0; e_g <= '0; e_p <= '0; e_w <= '0;
      e_nfo <= '0; e_se <= '0; e_used <= '0;
    end else begin
      if (lk_valid && ok) e_used[sel] <= 1'b1;
      if (wr_en) begin
        e_v[wr_idx]    <= wr_valid;
        e_g[wr_idx]    <= wr_global;
        e_p[wr_idx]    <= wr_priv;
        e_w[wr_idx]    <= wr_wok;
        e_nfo[wr_idx]  <= wr_nfo;
        e_se[wr_idx]   <= wr_se;
        e_used[wr_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_pa       <= '0;
      rsp_exc      <= 2'd0;
      rsp_ft       <= 3'b000;
      rsp_rd       <= 1'b0;
      rsp_wr       <= 1'b0;
      rsp_was_used <= 1'b0;
      tag_access   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit      <= hit;
        rsp_pa       <= hit ? {ppn, {PG_LSB{1'b0}}} : '0;
        rsp_exc      <= exc;
        rsp_ft       <= ft;
        rsp_rd       <= ok;
        rsp_wr       <= ok & e_w[sel];
        rsp_was_used <= hit & e_used[sel];
        if (exc != 2'd0) tag_access <= {lk_vpn, ctx};
      end
    end
  end

endmodule

// File: rtl/vps_tlb_chk.sv
module vps_tlb_chk #(
  parameter int PA_W = 41,
  parameter int TA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [1:0]      lk_kind,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_pa,
  input logic [1:0]      rsp_exc,
  input logic [2:0]      rsp_ft,
  input logic            rsp_rd,
  input logic            rsp_wr,
  input logic            rsp_was_used,
  input logic [TA_W-1:0] tag_access
);

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 2'd1) |-> (!rsp_hit && rsp_pa == '0 && rsp_ft == 3'b000));

  a_r6_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 2'd0) |-> (rsp_rd && rsp_hit));

  a_r6_no_grant_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc != 2'd0) |-> (!rsp_rd && !rsp_wr));

  a_r5_prot_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 2'd2) |-> (rsp_ft == 3'b000 && rsp_hit && $past(lk_kind) == 2'd1));

  a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 2'd3) |-> (rsp_ft != 3'b000));

  a_r9_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 2'd0) |-> $stable(tag_access));

  a_r7_used_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_was_used |-> rsp_hit);

endmodule

bind vps_tlb vps_tlb_chk #(.PA_W(PA_W), .TA_W(TA_W)) u_chk (.*);

// File: tb/tb_vps_tlb.sv
module tb_vps_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int ENT = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic wr_valid = 1'b0;
  logic [50:0] wr_vpn = '0;
  logic [12:0] wr_ctx = '0;
  logic [27:0] wr_ppn = '0;
  logic [1:0] wr_size = '0;
  logic wr_global = 0, wr_priv = 0, wr_wok = 0, wr_nfo = 0, wr_se = 0;
  logic lk_valid = 1'b0;
  logic [50:0] lk_vpn = '0;
  logic [1:0] lk_kind = '0;
  logic lk_user = 0, lk_sec = 0, lk_trap = 0;
  logic [12:0] prim_ctx = 13'd5, sec_ctx = 13'd9;
  logic rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_was_used;
  logic [40:0] rsp_pa;
  logic [1:0] rsp_exc;
  logic [2:0] rsp_ft;
  logic [63:0] tag_access;

  vps_tlb #(.ENTRIES(ENT)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit          s_v[ENT], s_g[ENT], s_p[ENT], s_w[ENT], s_nfo[ENT], s_se[ENT], s_used[ENT];
  logic [63:0] s_va[ENT], s_pa[ENT];
  logic [12:0] s_ctx[ENT];
  int          s_sz[ENT];
  logic [63:0] exp_tag = '0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input int idx, input bit v, input logic [63:0] va, input logic [12:0] c,
                     input logic [63:0] pa, input int sz, input bit g, p, w, nfo, se);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_valid = v; wr_vpn = va[63:13]; wr_ctx = c;
    wr_ppn = pa[40:13]; wr_size = 2'(sz); wr_global = g; wr_priv = p; wr_wok = w;
    wr_nfo = nfo; wr_se = se;
    @(posedge clk);
    s_v[idx] = v; s_va[idx] = va; s_ctx[idx] = c; s_pa[idx] = pa; s_sz[idx] = sz;
    s_g[idx] = g; s_p[idx] = p; s_w[idx] = w; s_nfo[idx] = nfo; s_se[idx] = se; s_used[idx] = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < ENT; i++) put(i, 0, 64'h0, 13'd0, 64'h0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(input logic [63:0] va, input int kind, input bit user, sec, trap, input string req);
    logic [12:0] c;
    bit h; int ix; logic [63:0] pb, epa;
    logic [2:0] eft; logic [1:0] eexc; bit erd, ewr, eused;
    c = (kind == 2) ? (trap ? 13'd0 : prim_ctx) : (sec ? sec_ctx : prim_ctx);
    h = 0; ix = 0;
    for (int i = ENT - 1; i >= 0; i--) begin
      logic [63:0] b;
      b = 64'd8192 << (3 * s_sz[i]);
      if (s_v[i] && (va / b == s_va[i] / b) && (s_g[i] || s_ctx[i] == c)) begin h = 1; ix = i; end
    end
    pb = 64'd8192 << (3 * s_sz[ix]);
    epa = h ? ((((s_pa[ix] / pb) * pb) + (va % pb)) % (64'd1 << 41)) / 8192 * 8192 : 64'h0;
    eft = h ? {s_p[ix] & user, bit'(kind == 3) & s_se[ix], bit'(kind < 2) & s_nfo[ix]} : 3'b000;
    if (!h) eexc = 1;
    else if (eft != 0) eexc = 3;
    else if (kind == 1 && !s_w[ix]) eexc = 2;
    else eexc = 0;
    erd = (eexc == 0);
    ewr = erd & s_w[ix];
    eused = h & s_used[ix];
    @(negedge clk);
    lk_valid = 1; lk_vpn = va[63:13]; lk_kind = 2'(kind); lk_user = user; lk_sec = sec; lk_trap = trap;
    @(posedge clk);
    if (erd) s_used[ix] = 1;
    if (eexc != 0) exp_tag = {va[63:13], c};
    @(negedge clk);
    lk_valid = 0;
    chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(req, "rsp_hit", 64'(rsp_hit), 64'(h));
    chk(req, "rsp_exc", 64'(rsp_exc), 64'(eexc));
    chk(req, "rsp_ft", 64'(rsp_ft), 64'(eft));
    chk(req, "rsp_pa", 64'(rsp_pa), epa);
    chk(req, "rsp_rd", 64'(rsp_rd), 64'(erd));
    chk(req, "rsp_wr", 64'(rsp_wr), 64'(ewr));
    chk(req, "rsp_was_used", 64'(rsp_was_used), 64'(eused));
    chk(req, "tag_access", tag_access, exp_tag);
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin
      s_v[i] = 0; s_used[i] = 0; s_sz[i] = 0; s_va[i] = 0; s_pa[i] = 0; s_ctx[i] = 0;
      s_g[i] = 0; s_p[i] = 0; s_w[i] = 0; s_nfo[i] = 0; s_se[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11", "reset tag_access", tag_access, 64'd0);
    look(64'h0000_0000_0040_2000, 0, 0, 0, 0, "R11 R8 empty after reset");

    // R1 R3: every size, probed inside and just outside its page
    for (int s = 0; s < 4; s++) begin
      logic [63:0] vb, pbase, pb;
      vb = 64'h0000_1234_0000_0000 + (64'(s) << 24);
      pbase = 64'h0000_01A0_0000_0000 + (64'(s) << 24) + 64'h003F_E000;
      pb = 64'd8192 << (3 * s);
      put(s, 1, vb, 13'd5, pbase, s, 0, 0, 1, 0, 0);
      look(vb, 0, 0, 0, 0, "R1 R3 first byte");
      look(vb + pb - 64'd1, 0, 0, 0, 0, "R1 R3 last byte");
      look(vb + pb / 3, 1, 0, 0, 0, "R3 R6 middle store");
      look(vb + pb, 0, 0, 0, 0, "R1 R8 past end");
      look(vb - 64'd1, 0, 0, 0, 0, "R1 R8 before start");
      look(vb ^ 64'h8000_0000_0000_0000, 0, 0, 0, 0, "R1 R8 top bit differs");
    end

    // R2: context selection
    clear_all();
    put(4, 1, 64'h0000_0000_1000_0000, 13'd5, 64'h0000_0000_2000_0000, 0, 0, 0, 1, 0, 0);
    put(5, 1, 64'h0000_0000_3000_0000, 13'd0, 64'h0000_0000_4000_0000, 1, 0, 0, 1, 0, 0);
    put(6, 1, 64'h0000_0000_5000_0000, 13'd77, 64'h0000_0000_6000_0000, 2, 1, 0, 0, 0, 0);
    look(64'h0000_0000_1000_0000, 0, 0, 0, 0, "R2 primary hit");
    look(64'h0000_0000_1000_0000, 0, 0, 1, 0, "R2 secondary miss");
    sec_ctx = 13'd5;
    look(64'h0000_0000_1000_0000, 1, 0, 1, 0, "R2 secondary hit");
    prim_ctx = 13'd6;
    look(64'h0000_0000_1000_0000, 2, 0, 0, 0, "R2 fetch primary mismatch");
    look(64'h0000_0000_3000_0000, 2, 0, 0, 1, "R2 fetch at trap uses ctx 0");
    look(64'h0000_0000_3000_0000, 2, 0, 0, 0, "R2 fetch trap level 0 miss");
    look(64'h0000_0000_5000_0000, 0, 1, 0, 0, "R2 global any ctx");
    look(64'h0000_0000_5000_0000, 2, 0, 0, 1, "R2 global at trap");
    prim_ctx = 13'd5; sec_ctx = 13'd9;

    // R4 R5 R6 R9: sweep attribute combinations against every kind and privilege
    clear_all();
    for (int a = 0; a < 32; a++) begin
      put(3, 1, 64'h0000_0007_0000_0000, 13'd5, 64'h0000_0123_4000_0000, a % 4,
          a[0], a[1], a[2], a[3], a[4]);
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++)
          look(64'h0000_0007_0000_2000 + 64'(k * 8192), k, u[0], 0, 0, "R4 R5 R6 R9 attr sweep");
    end

    // R7: used bit
    clear_all();
    put(2, 1, 64'h0000_0000_0080_0000, 13'd5, 64'h0000_0000_0090_0000, 0, 0, 1, 0, 0, 0);
    look(64'h0000_0000_0080_0000, 0, 1, 0, 0, "R7 fault leaves used clear");
    look(64'h0000_0000_0080_0000, 0, 0, 0, 0, "R7 first success");
    look(64'h0000_0000_0080_0000, 0, 0, 0, 0, "R7 second sees used");
    put(2, 1, 64'h0000_0000_0080_0000, 13'd5, 64'h0000_0000_0090_0000, 0, 0, 1, 0, 0, 0);
    look(64'h0000_0000_0080_0000, 0, 0, 0, 0, "R7 rewrite clears used");

    // R10: overlapping entries, lowest index wins
    put(1, 1, 64'h0000_0000_00C0_0000, 13'd5, 64'h0000_0000_0A00_0000, 3, 0, 0, 0, 0, 0);
    put(0, 1, 64'h0000_0000_00C0_0000, 13'd5, 64'h0000_0000_0B00_0000, 0, 0, 0, 1, 0, 0);
    look(64'h0000_0000_00C0_0000, 1, 0, 0, 0, "R10 low index wins");
    look(64'h0000_0000_00C0_4000, 1, 0, 0, 0, "R10 only large entry covers");
    put(0, 0, 64'h0000_0000_00C0_0000, 13'd5, 64'h0, 0, 0, 0, 0, 0, 0);
    look(64'h0000_0000_00C0_0000, 1, 0, 0, 0, "R10 R5 invalid low entry ignored");

    @(negedge clk);
    chk("R11", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule